// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel attached to a free-running timer counter. It watches an asynchronous input pin and records when an external event happens. The pin first passes through a synchronizer clocked by the system clock. A one-cycle delay stage then finds rising and falling transitions. A programmable edge selection decides which transitions count as events. On a qualifying event, and only while the timer is running, the channel copies the whole counter value into its capture register. It also raises a sticky event flag. The flag drives an interrupt request only when the channel's interrupt enable is set.

Software reads the captured count one byte at a time through a small read port. Reading the low byte also saves the high byte of the same capture into a shadow register. A later high-byte read then returns a value that matches the low byte, even if another capture has happened in between. In capture mode the channel never drives its pin, and the output-enable it presents to the pad stays low.

The event flag is a two-state machine. FLG_IDLE moves to FLG_PEND on a capture pulse. FLG_PEND moves back to FLG_IDLE on a clear strobe, provided no capture pulse arrives in the same cycle. In every other case each state holds. The edge qualifier is a decoder for four select codes (NONE, RISE, FALL, BOTH). It has no states of its own.

Top module: `tcap_channel`

## Requirements
- R1: `pad_oe_o` is 0 at all times, so the pin is never driven by the channel.
- R2: `edge_sel_i` selects the trigger: 2'b01 captures on a low-to-high pin transition only, 2'b10 on a high-to-low transition only, 2'b11 on either, and 2'b00 on none.
- R3: If the pin changes before rising clock edge k, the capture register takes the value `cnt_i` has just before clock edge k+2 (two synchronizer stages and one edge stage).
- R4: A pin pulse that begins and ends between two consecutive rising clock edges causes no capture and no flag.
- R5: Every capture sets `flag_o`, and it stays set until `flag_clr_i` is high at a clock edge.
- R6: When a capture and `flag_clr_i` happen at the same clock edge, `flag_o` remains 1.
- R7: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` is 1.
- R8: While `run_i` is 0, pin transitions cause no capture: the capture register and `flag_o` are unchanged.
- R9: A read with `rd_en_i`=1 and `rd_hi_i`=0 puts capture bits [7:0] on `rd_data_o` after the next clock edge and saves bits [15:8] into a shadow register. A read with `rd_hi_i`=1 returns that shadow, even if a newer capture happened after the low-byte read.
- R10: After reset the capture register, shadow, `rd_data_o` and `flag_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Current timer counter value |
| run_i | input | 1 | Timer is running |
| pin_i | input | 1 | Asynchronous capture pin |
| edge_sel_i | input | 2 | Trigger select: 00 none, 01 rising, 10 falling, 11 either |
| irq_en_i | input | 1 | Channel interrupt enable |
| flag_clr_i | input | 1 | Clear strobe for the event flag |
| rd_en_i | input | 1 | Read strobe for the byte read port |
| rd_hi_i | input | 1 | Byte select: 0 low (latches shadow), 1 high (shadow) |
| rd_data_o | output | 8 | Registered read data |
| pad_oe_o | output | 1 | Pad output enable, held low |
| flag_o | output | 1 | Sticky channel event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The main capture path is tried with a table covering each of the four select codes, each applied to a rising transition and to a falling transition. This separates a qualifier that confuses polarity, ignores a select bit, or fires on the wrong code. Each expected capture is checked against the counter value two cycles after the pin change. That distinguishes the intended latency from one stage more or less. Further patterns use a sub-cycle glitch, transitions with the timer stopped, a clear that coincides with a capture, and a capture placed between a low-byte and a high-byte read. These show the filtering, the run gating, the flag priority and the shadow coherence.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;

endpackage

// File: rtl/tcap_sync_edge.sv
module tcap_sync_edge
    import tcap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       run_i,
    input  logic [1:0] edge_sel_i,
    output logic       cap_pulse_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   dly_q;
    logic                   pin_s;
    logic                   rise;
    logic                   fall;
    logic                   hit;
    edge_sel_e              sel;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            end
        end
    endgenerate

    assign pin_s = sync_q[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= 1'b0;
        else        dly_q <= pin_s;
    end

    always_comb begin
        sel  = edge_sel_e'(edge_sel_i);
        rise = pin_s & ~dly_q;
        fall = ~pin_s & dly_q;
        unique case (sel)
            EDGE_NONE: hit = 1'b0;
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        cap_pulse_o = hit & run_i;
    end

    // R2: a rising-only trigger fires only when the synchronized pin has just gone high
    assert_rise_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_pulse_o && edge_sel_i == 2'b01) |-> (pin_s && !dly_q));

    // R2: a falling-only trigger fires only when the synchronized pin has just gone low
    assert_fall_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_pulse_o && edge_sel_i == 2'b10) |-> (!pin_s && dly_q));

    // R4: a pulse needs the delay stage to differ from the synchronizer output
    assert_edge_needs_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse_o |-> (pin_s != dly_q));

endmodule

// File: rtl/tcap_flag_fsm.sv
module tcap_flag_fsm
    import tcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_pulse_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (cap_pulse_i)          state_d = FLG_PEND;
            FLG_PEND: if (clr_i && !cap_pulse_i) state_d = FLG_IDLE;
            default:                             state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_o = (state_q == FLG_PEND);
        irq_o  = flag_o & irq_en_i;
    end

    // R5: every capture leaves the flag set
    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse_i |=> flag_o);

    // R5: a lone clear drops the flag
    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !cap_pulse_i) |=> !flag_o);

    // R5: without a clear, a set flag stays set
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    // R6: capture beats a coincident clear
    assert_capture_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_pulse_i && clr_i) |=> flag_o);

endmodule

// File: rtl/tcap_capture_reg.sv
module tcap_capture_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pulse_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cap_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cap_o <= '0;
        else if (cap_pulse_i) cap_o <= cnt_i;
    end

    // R3: the register holds the counter value present at the capture edge
    assert_capture_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse_i |=> (cap_o == $past(cnt_i)));

    // R8: no capture pulse, no change
    assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse_i |=> $stable(cap_o));

endmodule

// File: rtl/tcap_readout.sv
module tcap_readout #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*BYTE_W-1:0] cap_i,
    input  logic                rd_en_i,
    input  logic                rd_hi_i,
    output logic [BYTE_W-1:0]   rd_data_o
);

    localparam int CNT_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_o <= '0;
            shadow_q  <= '0;
        end else if (rd_en_i) begin
            if (!rd_hi_i) begin
                rd_data_o <= cap_i[BYTE_W-1:0];
                shadow_q  <= cap_i[CNT_W-1:BYTE_W];
            end else begin
                rd_data_o <= shadow_q;
            end
        end
    end

    // R9: a low-byte read returns the low half of the capture register
    assert_low_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !rd_hi_i) |=> (rd_data_o == $past(cap_i[BYTE_W-1:0])));

    // R9: a low-byte read followed by a high-byte read pairs halves of one capture
    assert_pair_coherent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !rd_hi_i) |=> (rd_en_i && rd_hi_i) |=> (rd_data_o == $past(cap_i[CNT_W-1:BYTE_W], 2)));

    // R9: the read data changes only on a read strobe
    assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));

endmodule

// File: rtl/tcap_channel.sv
module tcap_channel #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              run_i,
    input  logic              pin_i,
    input  logic [1:0]        edge_sel_i,
    input  logic              irq_en_i,
    input  logic              flag_clr_i,
    input  logic              rd_en_i,
    input  logic              rd_hi_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              pad_oe_o,
    output logic              flag_o,
    output logic              irq_o
);

    logic             cap_pulse;
    logic [CNT_W-1:0] cap_value;

    assign pad_oe_o = 1'b0;

    tcap_sync_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin_i),
        .run_i       (run_i),
        .edge_sel_i  (edge_sel_i),
        .cap_pulse_o (cap_pulse)
    );

    tcap_capture_reg #(
        .CNT_W (CNT_W)
    ) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_pulse_i (cap_pulse),
        .cnt_i       (cnt_i),
        .cap_o       (cap_value)
    );

    tcap_flag_fsm u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_pulse_i (cap_pulse),
        .clr_i       (flag_clr_i),
        .irq_en_i    (irq_en_i),
        .flag_o      (flag_o),
        .irq_o       (irq_o)
    );

    tcap_readout #(
        .BYTE_W (BYTE_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_i     (cap_value),
        .rd_en_i   (rd_en_i),
        .rd_hi_i   (rd_hi_i),
        .rd_data_o (rd_data_o)
    );

    // R8: while the timer is stopped the captured value stays put
    assert_stopped_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(cap_value));

    // R8: while the timer is stopped the flag cannot rise
    assert_stopped_noflag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !flag_o) |=> !flag_o);

    // R7: an interrupt request implies a pending flag
    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_o && irq_en_i));

endmodule

// File: tb/tcap_channel_tb.sv
module tcap_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = 16'h0;
    logic        ld_req = 1'b0;
    logic [15:0] ld_val = 16'h0;
    logic        run = 1'b1;
    logic        pin = 1'b0;
    logic [1:0]  sel = 2'b00;
    logic        irq_en = 1'b0;
    logic        clr = 1'b0;
    logic        rd_en = 1'b0;
    logic        rd_hi = 1'b0;
    logic [7:0]  rd_data;
    logic        pad_oe;
    logic        flag;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] last_cap = 16'h0;
    logic [15:0] c0;
    logic [15:0] got;
    logic [15:0] cap_a;
    logic [7:0]  byte_lo;

    // vector: {sel[1:0], start level, capture expected}
    localparam logic [3:0] VEC [8] = '{
        4'b01_0_1, 4'b01_1_0, 4'b10_0_0, 4'b10_1_1,
        4'b11_0_1, 4'b11_1_1, 4'b00_0_0, 4'b00_1_0
    };

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (ld_req) cnt <= ld_val;
        else        cnt <= cnt + 16'd1;
    end

    tcap_channel u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (cnt),
        .run_i      (run),
        .pin_i      (pin),
        .edge_sel_i (sel),
        .irq_en_i   (irq_en),
        .flag_clr_i (clr),
        .rd_en_i    (rd_en),
        .rd_hi_i    (rd_hi),
        .rd_data_o  (rd_data),
        .pad_oe_o   (pad_oe),
        .flag_o     (flag),
        .irq_o      (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic load_cnt(input logic [15:0] v);
        @(negedge clk); ld_req = 1'b1; ld_val = v;
        @(negedge clk); ld_req = 1'b0;
    endtask

    task automatic read_lo(output logic [7:0] b);
        @(negedge clk); rd_en = 1'b1; rd_hi = 1'b0;
        @(negedge clk); b = rd_data; rd_en = 1'b0;
    endtask

    task automatic read_hi(output logic [7:0] b);
        @(negedge clk); rd_en = 1'b1; rd_hi = 1'b1;
        @(negedge clk); b = rd_data; rd_en = 1'b0; rd_hi = 1'b0;
    endtask

    task automatic read16(output logic [15:0] v);
        logic [7:0] l;
        logic [7:0] h;
        read_lo(l);
        read_hi(h);
        v = {h, l};
    endtask

    // set pin level with triggering off so no capture happens
    task automatic park_pin(input logic lvl);
        @(negedge clk); sel = 2'b00; pin = lvl;
        wait_n(4);
    endtask

    // toggle pin at a falling clock edge and note the counter there
    task automatic toggle_pin();
        @(negedge clk); c0 = cnt; pin = ~pin;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 / R1: reset state
        chk("R10 flag after reset", flag, 0);
        chk("R10 irq after reset", irq, 0);
        chk("R1 pad output enable", pad_oe, 0);
        read16(got);
        chk("R10 capture after reset", got, 16'h0);

        // R2 / R3: edge-select table
        for (int i = 0; i < 8; i++) begin
            park_pin(VEC[i][1]);
            clear_flag();
            @(negedge clk); sel = VEC[i][3:2];
            toggle_pin();
            wait_n(4);
            chk($sformatf("R2 flag vector %0d", i), flag, VEC[i][0]);
            read16(got);
            if (VEC[i][0]) begin
                chk($sformatf("R3 captured count vector %0d", i), got, c0 + 16'd2);
                last_cap = c0 + 16'd2;
            end else begin
                chk($sformatf("R2 no capture vector %0d", i), got, last_cap);
            end
        end

        // R5: flag is sticky, then cleared by the strobe
        park_pin(1'b0);
        clear_flag();
        @(negedge clk); sel = 2'b01;
        toggle_pin();
        wait_n(12);
        chk("R5 flag sticky", flag, 1);
        read16(got);
        last_cap = got;
        clear_flag();
        chk("R5 flag cleared", flag, 0);

        // R7: interrupt gating
        park_pin(1'b0);
        @(negedge clk); sel = 2'b01; irq_en = 1'b0;
        toggle_pin();
        wait_n(4);
        chk("R7 irq masked", irq, 0);
        @(negedge clk); irq_en = 1'b1;
        @(negedge clk);
        chk("R7 irq raised", irq, 1);
        clear_flag();
        chk("R7 irq after clear", irq, 0);
        @(negedge clk); irq_en = 1'b0;
        read16(got);
        last_cap = got;

        // R6: clear in the capture cycle loses
        park_pin(1'b0);
        clear_flag();
        @(negedge clk); sel = 2'b01;
        toggle_pin();
        @(negedge clk);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk("R6 capture beats clear", flag, 1);
        read16(got);
        chk("R6 capture value", got, c0 + 16'd2);
        last_cap = got;

        // R8: timer stopped
        park_pin(1'b0);
        clear_flag();
        @(negedge clk); sel = 2'b11; run = 1'b0;
        toggle_pin();
        wait_n(4);
        chk("R8 no flag when stopped", flag, 0);
        read16(got);
        chk("R8 capture unchanged when stopped", got, last_cap);
        @(negedge clk); run = 1'b1;

        // R4: glitch between clock edges
        park_pin(1'b0);
        @(negedge clk); sel = 2'b11;
        @(negedge clk); pin = 1'b1; #2; pin = 1'b0;
        wait_n(4);
        chk("R4 glitch no flag", flag, 0);
        read16(got);
        chk("R4 glitch no capture", got, last_cap);

        // R9: shadow keeps high byte across a newer capture
        load_cnt(16'h12F0);
        @(negedge clk); sel = 2'b11;
        toggle_pin();
        wait_n(4);
        cap_a = c0 + 16'd2;
        read_lo(byte_lo);
        chk("R9 low byte", byte_lo, cap_a[7:0]);
        load_cnt(16'hAB00);
        toggle_pin();
        wait_n(4);
        read_hi(byte_lo);
        chk("R9 high byte from shadow", byte_lo, cap_a[15:8]);
        read16(got);
        chk("R9 newer capture", got, c0 + 16'd2);
        clear_flag();

        chk("R1 pad output enable at end", pad_oe, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule